// File: doc/BRIEF.md
# Fixed-Address Output Port Register

This block is a write-only output port on an I/O-mapped bus with separate memory and I/O spaces. It compares the 8-bit low-order port address against one fixed value. It also merges the active-low I/O-request and write strobes into an I/O-write condition. When both agree, it raises an active-high select. While select is high, the byte on the data bus is taken into an 8-bit holding register on every clock edge. When select drops, the last byte stays in the register.

The stored byte drives two outputs. The first is a bank of eight LED sink lines, which carry the inverse of the stored bits. A stored 1 pulls its line low and lights an LED tied to the supply. The second is an 8-bit segment bus for a common-anode seven-segment display. It carries the stored bits unchanged through a per-bit three-state stage gated by an active-low enable. Software writes segment codes in which a 0 lights a segment.

Top module: `out_port_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored byte to 0x00. After reset, `led_n` reads 0xFF and, with `oe_n` low, `seg_n` reads 0x00.
- R2: Only port address 0x07 can load the register. An I/O write to any other address leaves the stored byte unchanged.
- R3: The I/O-write condition needs `iorq_n` and `wr_n` to be low in the same cycle. A cycle with either strobe high, including a read cycle (`wr_n` high), leaves the stored byte unchanged.
- R4: `port_sel` is high exactly when the address is 0x07 and both strobes are low. It follows the inputs combinationally.
- R5: While `port_sel` is high, each rising clock edge copies the data bus into the register. If select stays high over several cycles, the register follows changing data, and each value appears on the outputs after that edge.
- R6: Once `port_sel` goes low, the byte captured at the last selected edge is held until the next selected edge, whatever the data bus does.
- R7: `led_n[i]` is the inverse of stored bit i. Writing 0x97 gives `led_n` = 0x68, so the LEDs on bits 0, 1, 2, 4 and 7 light.
- R8: Segment mapping: `seg_n` bit 0 is segment A, bits 1 to 6 are B to G, and bit 7 is the decimal point. A segment lights on 0. Writing 0x79 drives bits 1 and 2 (B and C) low and bits 0 and 3 to 6 high, so the display shows the digit 1.
- R9: With `oe_n` high, all `seg_n` lines are high-impedance. With `oe_n` low, they carry the stored byte. `oe_n` has no effect on the stored byte or on `led_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Low-order port address |
| data | input | 8 | Data bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Segment output enable, active low |
| port_sel | output | 1 | Decoded I/O-write select, active high |
| led_n | output | 8 | LED sink lines, inverse of stored byte |
| seg_n | output | 8 | Segment lines (A..G, DP), three-state |

## Verification
The assertions assume that the address, data and strobes are synchronous to `clk`. They are sampled only at rising edges, and a select that lasts less than one clock is not seen. The assertions also assume that reset is high at the first edge. The bench keeps to these assumptions: it changes every input only on the falling edge and starts in reset. Its random mix sends about half the cycles to address 0x07 and sets each strobe low about half the time, so selected writes, misaddressed writes, reads and idle cycles all occur. Directed runs add held-select sequences, the two display codes and enable toggling.

// File: rtl/oport_pkg.sv
package oport_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] PORT_ADDR = 8'h07;
  // Segment positions on the segment bus
  localparam int unsigned SEG_A  = 0;
  localparam int unsigned SEG_B  = 1;
  localparam int unsigned SEG_C  = 2;
  localparam int unsigned SEG_G  = 6;
  localparam int unsigned SEG_DP = 7;
endpackage

// File: rtl/port_decode.sv
module port_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h07
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic              sel
);
  logic addr_hit;
  logic iow_n;

  // Strobes are active low: the write condition is a negative-input AND
  assign iow_n    = iorq_n | wr_n;
  assign addr_hit = (addr == PORT_ADDR);
  assign sel      = addr_hit & ~iow_n;
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  // Clocked stand-in for a level-transparent latch: follows din while load is high
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  assert_follow_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/out_drive.sv
module out_drive #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] q,
  input  logic              oe_n,
  output logic [DATA_W-1:0] led_n,
  output wire  [DATA_W-1:0] seg_n
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // LED sinks current when the stored bit is 1
    assign led_n[i] = ~q[i];
    // Common-anode segment: stored 0 lights it; released when disabled
    assign seg_n[i] = oe_n ? 1'bz : q[i];
  end
endmodule

// File: rtl/out_port_latch.sv
module out_port_latch
  import oport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              oe_n,
  output logic              port_sel,
  output logic [DATA_W-1:0] led_n,
  output wire  [DATA_W-1:0] seg_n
);
  logic [DATA_W-1:0] stored;

  port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(addr), .iorq_n(iorq_n), .wr_n(wr_n), .sel(port_sel)
  );

  hold_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .load(port_sel), .din(data), .q(stored)
  );

  out_drive #(.DATA_W(DATA_W)) u_drv (
    .q(stored), .oe_n(oe_n), .led_n(led_n), .seg_n(seg_n)
  );

  assert_other_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (addr != PORT_ADDR) |=> $stable(led_n));

  assert_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (iorq_n || wr_n) |=> $stable(led_n));

  assert_sel_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    port_sel |-> (!iorq_n && !wr_n));

  assert_polarity_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (seg_n == ~led_n));
endmodule

// File: tb/out_port_latch_test.sv
module out_port_latch_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] data = 8'h00;
  logic       iorq_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       oe_n = 1'b0;
  logic       port_sel;
  logic [7:0] led_n;
  tri1  [7:0] seg_w;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model = 8'h00;
  bit done = 1'b0;

  out_port_latch uut (
    .clk(clk), .rst(rst), .addr(addr), .data(data), .iorq_n(iorq_n),
    .wr_n(wr_n), .oe_n(oe_n), .port_sel(port_sel), .led_n(led_n), .seg_n(seg_w)
  );

  always #10 clk = ~clk;

  function automatic logic exp_sel(input logic [7:0] a, input logic rq, input logic w);
    return (a == 8'h07) && !rq && !w;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs checked against the model after the edge
  task automatic check_outs(input string req);
    check({req, " led"}, led_n, ~model);
    if (oe_n) check({req, " R9 released"}, seg_w, 8'hFF);
    else      check({req, " seg"}, seg_w, model);
  endtask

  // One bus cycle: drive at negedge, check select, let the edge act, check outputs
  task automatic cycle(input logic [7:0] a, input logic [7:0] d, input logic rq,
                       input logic w, input logic oe, input string req);
    @(negedge clk);
    addr = a; data = d; iorq_n = rq; wr_n = w; oe_n = oe;
    #2;
    check("R4 sel", {7'b0, port_sel}, {7'b0, exp_sel(a, rq, w)});
    @(posedge clk);
    if (exp_sel(a, rq, w)) model = d;
    #2;
    check_outs(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    check_outs("R1 reset");

    // R7: display 0x97 on the LEDs
    cycle(8'h07, 8'h97, 1'b0, 1'b0, 1'b0, "R7 0x97");
    check("R7 led 0x97", led_n, 8'h68);
    // R8: digit one code
    cycle(8'h07, 8'h79, 1'b0, 1'b0, 1'b0, "R8 0x79");
    check("R8 seg B C lit", seg_w & 8'h7F, 8'h79);
    check("R8 segA off", {7'b0, seg_w[0]}, 8'h01);
    // R6: select dropped, data changes
    cycle(8'h07, 8'hAA, 1'b1, 1'b1, 1'b0, "R6 hold");
    check("R6 held", ~led_n, 8'h79);
    // R2: wrong addresses
    cycle(8'h06, 8'h11, 1'b0, 1'b0, 1'b0, "R2 addr06");
    cycle(8'h87, 8'h22, 1'b0, 1'b0, 1'b0, "R2 addr87");
    check("R2 unchanged", ~led_n, 8'h79);
    // R3: read cycle and memory write
    cycle(8'h07, 8'h33, 1'b0, 1'b1, 1'b0, "R3 read");
    cycle(8'h07, 8'h44, 1'b1, 1'b0, 1'b0, "R3 memwr");
    check("R3 unchanged", ~led_n, 8'h79);
    // R5: held select with changing data
    for (int k = 0; k < 4; k++) begin
      cycle(8'h07, 8'h10 + 8'(k * 3), 1'b0, 1'b0, 1'b0, "R5 follow");
      check("R5 follow value", ~led_n, 8'h10 + 8'(k * 3));
    end
    // R9: release and re-enable the segment bus
    cycle(8'h07, 8'h00, 1'b0, 1'b0, 1'b1, "R9 off");
    check("R9 hi-z", seg_w, 8'hFF);
    check("R9 led unaffected", led_n, 8'hFF);
    cycle(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R9 on");
    check("R9 enabled", seg_w, 8'h00);

    // Random mix with a fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'h07 : 8'($urandom);
      cycle(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0), "R2 R3 R5 R6 rand");
    end

    // R1: reset wins over an active select
    @(negedge clk);
    rst = 1'b1; addr = 8'h07; data = 8'h5C; iorq_n = 1'b0; wr_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    model = 8'h00;
    #2;
    check_outs("R1 reset over write");
    @(negedge clk);
    rst = 1'b0; iorq_n = 1'b1; wr_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule